// File: doc/BRIEF.md
# Sync and Frame Delimiter Detector

This receive-side block watches a recovered serial bit stream, qualified by a one-cycle strobe per bit, and hunts for a programmed sync pattern. Once that pattern is seen, it looks for a longer programmed frame delimiter. Every bit that follows the delimiter is passed on as user data. A found-flag is raised for each pattern and held for the rest of the reception.

A search timer bounds the hunt for sync. If the timer runs out, a done flag is raised and an active-low interrupt is asserted. A noise or long-run indication from the channel assessment logic also ends the hunt, and that early end raises the same done flag and interrupt. From the done flag and the latched indications, the block forms a two-way channel verdict: busy or clear.

Receive is commanded by an active-low input. That input must stay low for the whole search and reception. Driving it high ends the reception and clears every flag.

Top module: `sync_frame_detector`

## Requirements
- R1: While `rx_go_n` is high, strobed bits are not examined, and neither `sync_found` nor `frame_found` can rise.
- R2: `sync_found` rises at the clock edge that samples the strobe completing a match of the last 11 received bits against `sync_pat`, with `sync_pat[10]` being the earliest bit. It then stays high while `rx_go_n` stays low.
- R3: The delimiter match only uses bits strobed after `sync_found` is high. `frame_found` rises at the edge that samples the strobe completing a match of those last 37 bits against `delim_pat`, with `delim_pat[36]` being the earliest bit. It then holds while `rx_go_n` is low.
- R4: For each strobe sampled while `frame_found` is high, `data_stb` pulses for one cycle on the following cycle, with `data_bit` equal to the strobed bit.
- R5: With neither sync nor an indication, `done_flag` rises on the SEARCH_CYCLES-th clock edge that samples `rx_go_n` low. `irq_n` falls on the same edge and stays low until `rx_go_n` returns high.
- R6: Once `sync_found` is high, the search timer stops and `done_flag` does not rise.
- R7: A `noise_in` or `long_in` sampled high during the search sets `done_flag` and lowers `irq_n` on that edge. A sync pattern sent afterwards is ignored.
- R8: `chan_busy` is high when `done_flag` is high and no indication was latched. `chan_clear` is high when `done_flag` is high and noise or long-run was latched. Both are low while `done_flag` is low.
- R9: One edge after `rx_go_n` is sampled high, `sync_found`, `frame_found`, `done_flag`, `chan_busy`, `chan_clear` and `data_stb` are low, and `irq_n` is high.
- R10: After reset, all flags are low and `irq_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_go_n | input | 1 | Active-low receive command |
| bit_in | input | 1 | Recovered serial bit |
| bit_stb | input | 1 | One-cycle strobe marking a valid `bit_in` |
| sync_pat | input | 11 | Sync pattern, earliest bit at MSB |
| delim_pat | input | 37 | Frame delimiter pattern, earliest bit at MSB |
| noise_in | input | 1 | Noise indication from channel assessment |
| long_in | input | 1 | Long-run indication from channel assessment |
| sync_found | output | 1 | Sync pattern detected |
| frame_found | output | 1 | Frame delimiter detected |
| done_flag | output | 1 | Search ended by timeout or indication |
| irq_n | output | 1 | Active-low interrupt request |
| chan_busy | output | 1 | Verdict: channel busy |
| chan_clear | output | 1 | Verdict: channel clear to transmit |
| data_bit | output | 1 | User data bit |
| data_stb | output | 1 | User data bit valid |

## Verification
The bench probes the exact bit that completes each pattern. A design whose fill counter or comparison window is off by one would raise the flag one bit early or late. It also sends a sync pattern with receive idle, and again after a noise indication has ended the search; a design that kept hunting would raise `sync_found` in either case. The bench samples the timeout one edge before and on the expiry edge, and checks that the timer is frozen after sync, so an off-by-one counter or a timer that kept running would show. User data bits travel through a scoreboard queue, so a dropped, duplicated or delimiter-leaking bit produces a mismatch.

// File: rtl/sfd_pkg.sv
// Shared defaults and the channel verdict type for the sync/frame detector.
package sfd_pkg;
    localparam int SFD_SYNC_W        = 11;
    localparam int SFD_DELIM_W       = 37;
    localparam int SFD_SEARCH_CYCLES = 4000;

    typedef enum logic [1:0] {
        VD_NONE  = 2'd0,
        VD_BUSY  = 2'd1,
        VD_CLEAR = 2'd2
    } verdict_t;
endpackage

// File: rtl/sfd_pattern_match.sv
// Serial pattern matcher: shifts in a bit on each enable and flags an exact
// match of the last W bits (earliest bit at pattern MSB).
// Assumes: clr empties the window; hit is combinational on the shift in progress.
module sfd_pattern_match #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic         bit_in,
    input  logic [W-1:0] pattern,
    output logic         hit
);
    localparam int CW = $clog2(W + 1);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic [W-1:0]  win_q;
    logic [CW-1:0] fill_q;
    logic [W-1:0]  win_nxt;

    // Window contents after the shift in progress.
    assign win_nxt = {win_q[W-2:0], bit_in};
    // Match once the window holds W real bits.
    assign hit = en && (fill_q >= LAST) && (win_nxt == pattern);

    // Shift register and saturating fill count.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            win_q  <= '0;
            fill_q <= '0;
        end else if (en) begin
            win_q <= win_nxt;
            if (fill_q < LAST + CW'(1))
                fill_q <= fill_q + CW'(1);
        end
    end
endmodule

// File: rtl/sfd_search_timer.sv
// Search down-counter: reloads while receive is idle, counts while the hunt
// runs, and pulses expire on the edge that takes it from 1 to 0.
// Assumes: N >= 1.
module sfd_search_timer #(
    parameter int N = 4000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic run,
    output logic expire
);
    localparam int CW = $clog2(N + 1);
    localparam logic [CW-1:0] LOAD = CW'(N);

    logic [CW-1:0] cnt_q;

    assign expire = run && (cnt_q == CW'(1));

    // Reload when idle, count down during the hunt, freeze otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !active)
            cnt_q <= LOAD;
        else if (run && cnt_q != '0)
            cnt_q <= cnt_q - CW'(1);
    end
endmodule

// File: rtl/sfd_status.sv
// Done flag, interrupt line, latched channel indications and verdict.
// Assumes: searching is high only while receive is active and no sync yet.
module sfd_status
    import sfd_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     active,
    input  logic     searching,
    input  logic     expire,
    input  logic     noise_in,
    input  logic     long_in,
    output logic     done_q,
    output logic     irq_n,
    output verdict_t verdict
);
    logic ns_q, lr_q;
    logic end_now;

    assign end_now = searching && (expire || noise_in || long_in);

    // Latch done, indications and interrupt; all cleared when receive stops.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            done_q <= 1'b0;
            ns_q   <= 1'b0;
            lr_q   <= 1'b0;
            irq_n  <= 1'b1;
        end else if (end_now) begin
            done_q <= 1'b1;
            ns_q   <= noise_in;
            lr_q   <= long_in;
            irq_n  <= 1'b0;
        end
    end

    // Two-way verdict from done and the latched indications.
    always_comb begin
        if (!done_q)
            verdict = VD_NONE;
        else if (ns_q || lr_q)
            verdict = VD_CLEAR;
        else
            verdict = VD_BUSY;
    end
endmodule

// File: rtl/sync_frame_detector.sv
// Top: hunts sync then frame delimiter in a strobed serial stream, bounds the
// hunt with a timer, and reports done, interrupt and channel verdict.
// Assumes: rx_go_n is held low for the whole search and reception.
module sync_frame_detector
    import sfd_pkg::*;
#(
    parameter int SYNC_W        = SFD_SYNC_W,
    parameter int DELIM_W       = SFD_DELIM_W,
    parameter int SEARCH_CYCLES = SFD_SEARCH_CYCLES
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rx_go_n,
    input  logic               bit_in,
    input  logic               bit_stb,
    input  logic [SYNC_W-1:0]  sync_pat,
    input  logic [DELIM_W-1:0] delim_pat,
    input  logic               noise_in,
    input  logic               long_in,
    output logic               sync_found,
    output logic               frame_found,
    output logic               done_flag,
    output logic               irq_n,
    output logic               chan_busy,
    output logic               chan_clear,
    output logic               data_bit,
    output logic               data_stb
);
    logic     active, searching;
    logic     sync_hit, delim_hit, expire;
    logic     sync_q, frame_q, done_q;
    verdict_t verdict;

    assign active    = ~rx_go_n;
    assign searching = active && !sync_q && !done_q;

    sfd_pattern_match #(.W(SYNC_W)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (!active),
        .en      (bit_stb && searching),
        .bit_in  (bit_in),
        .pattern (sync_pat),
        .hit     (sync_hit)
    );

    sfd_pattern_match #(.W(DELIM_W)) u_delim (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (!active),
        .en      (bit_stb && active && sync_q && !frame_q),
        .bit_in  (bit_in),
        .pattern (delim_pat),
        .hit     (delim_hit)
    );

    sfd_search_timer #(.N(SEARCH_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (active),
        .run    (searching),
        .expire (expire)
    );

    sfd_status u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (active),
        .searching (searching),
        .expire    (expire),
        .noise_in  (noise_in),
        .long_in   (long_in),
        .done_q    (done_q),
        .irq_n     (irq_n),
        .verdict   (verdict)
    );

    // Sticky found flags for the current reception.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            sync_q  <= 1'b0;
            frame_q <= 1'b0;
        end else begin
            if (sync_hit)  sync_q  <= 1'b1;
            if (delim_hit) frame_q <= 1'b1;
        end
    end

    // Forward user data bits one cycle after their strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_stb <= 1'b0;
            data_bit <= 1'b0;
        end else begin
            data_stb <= active && frame_q && bit_stb;
            data_bit <= bit_in;
        end
    end

    assign sync_found  = sync_q;
    assign frame_found = frame_q;
    assign done_flag   = done_q;
    assign chan_busy   = (verdict == VD_BUSY);
    assign chan_clear  = (verdict == VD_CLEAR);
endmodule

// File: rtl/sfd_checker.sv
// Temporal checks on the detector's ports, attached by bind.
module sfd_checker (
    input logic clk,
    input logic rst_n,
    input logic rx_go_n,
    input logic sync_found,
    input logic frame_found,
    input logic done_flag,
    input logic irq_n,
    input logic chan_busy,
    input logic chan_clear,
    input logic data_stb
);
    AST_SYNC_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        sync_found |=> (sync_found || $past(rx_go_n)));  // R2
    AST_FRAME_AFTER_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        frame_found |-> sync_found);  // R3
    AST_DATA_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        data_stb |-> $past(frame_found));  // R4
    AST_IRQ_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_n) |-> $rose(done_flag));  // R5
    AST_NO_DONE_AFTER_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_found && !done_flag) |=> !$rose(done_flag));  // R6
    AST_VERDICT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({chan_busy, chan_clear}) && ((chan_busy || chan_clear) == done_flag));  // R8
    AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        rx_go_n |=> (!sync_found && !frame_found && !done_flag && irq_n));  // R9
endmodule

bind sync_frame_detector sfd_checker u_chk (.*);

// File: tb/sync_frame_detector_test.sv
module sync_frame_detector_test;
    localparam int CLK_P = 10;
    localparam int NCYC  = 60;

    logic        clk = 1'b0, rst_n = 1'b0, rx_go_n = 1'b1;
    logic        bit_in = 1'b0, bit_stb = 1'b0, noise_in = 1'b0, long_in = 1'b0;
    logic [10:0] sync_pat  = 11'b10110011101;
    logic [36:0] delim_pat = 37'h1A5C3F0E7;
    logic        sync_found, frame_found, done_flag, irq_n;
    logic        chan_busy, chan_clear, data_bit, data_stb;

    int checks = 0, errors = 0;
    logic exp_q[$];
    bit   done_run = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    sync_frame_detector #(.SEARCH_CYCLES(NCYC)) uut (
        .clk(clk), .rst_n(rst_n), .rx_go_n(rx_go_n), .bit_in(bit_in),
        .bit_stb(bit_stb), .sync_pat(sync_pat), .delim_pat(delim_pat),
        .noise_in(noise_in), .long_in(long_in), .sync_found(sync_found),
        .frame_found(frame_found), .done_flag(done_flag), .irq_n(irq_n),
        .chan_busy(chan_busy), .chan_clear(chan_clear), .data_bit(data_bit),
        .data_stb(data_stb)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    // Driver: one strobed bit, optionally queued as expected user data.
    task automatic send_bit(input logic b, input bit expect_data);
        @(posedge clk); #1;
        bit_in = b; bit_stb = 1'b1;
        if (expect_data) exp_q.push_back(b);
        @(posedge clk); #1;
        bit_stb = 1'b0;
    endtask

    task automatic send_sync(input int n);
        for (int i = 10; i > 10 - n; i--) send_bit(sync_pat[i], 1'b0);
    endtask

    task automatic go_idle();
        @(posedge clk); #1 rx_go_n = 1'b1;
        @(posedge clk); #1;
    endtask

    // Monitor: compare each forwarded data bit with the scoreboard head.
    always @(negedge clk) begin
        if (rst_n && data_stb) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R4 actual=unexpected bit %0b expected=none", data_bit);
            end else begin
                logic e;
                e = exp_q.pop_front();
                if (data_bit !== e) begin
                    errors++;
                    $display("FAIL R4 actual=%0b expected=%0b", data_bit, e);
                end
            end
        end
    end

    initial begin
        #(CLK_P * 150000);
        if (!done_run) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] payload;
        payload = 16'hC53A;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        check("R10 sync", sync_found, 1'b0);
        check("R10 irq_n", irq_n, 1'b1);
        check("R10 done", done_flag, 1'b0);

        // R1: pattern sent with receive idle is ignored
        send_sync(11);
        check("R1 sync while idle", sync_found, 1'b0);

        // R2/R3/R4: sync, delimiter, then data
        @(posedge clk); #1 rx_go_n = 1'b0;
        send_sync(10);
        check("R2 sync one bit early", sync_found, 1'b0);
        send_bit(sync_pat[0], 1'b0);
        check("R2 sync on last bit", sync_found, 1'b1);
        for (int i = 36; i > 0; i--) send_bit(delim_pat[i], 1'b0);
        check("R3 frame one bit early", frame_found, 1'b0);
        send_bit(delim_pat[0], 1'b0);
        check("R3 frame on last bit", frame_found, 1'b1);
        for (int i = 15; i >= 0; i--) send_bit(payload[i], 1'b1);
        repeat (2) @(posedge clk);
        #1 check("R4 queue drained", exp_q.size() == 0, 1'b1);
        // R6: timer frozen after sync
        repeat (NCYC + 10) @(posedge clk);
        #1 check("R6 no done after sync", done_flag, 1'b0);
        check("R2 sync held", sync_found, 1'b1);
        go_idle();
        // R9: everything cleared
        check("R9 sync", sync_found, 1'b0);
        check("R9 frame", frame_found, 1'b0);

        // R5/R8: timeout gives busy
        rx_go_n = 1'b0;
        repeat (NCYC - 1) @(posedge clk);
        #1 check("R5 done before expiry", done_flag, 1'b0);
        check("R5 irq before expiry", irq_n, 1'b1);
        @(posedge clk); #1;
        check("R5 done at expiry", done_flag, 1'b1);
        check("R5 irq at expiry", irq_n, 1'b0);
        check("R8 busy", chan_busy, 1'b1);
        check("R8 clear", chan_clear, 1'b0);
        repeat (5) @(posedge clk);
        #1 check("R5 irq held", irq_n, 1'b0);
        go_idle();
        check("R9 done", done_flag, 1'b0);
        check("R9 irq_n", irq_n, 1'b1);
        check("R9 busy", chan_busy, 1'b0);

        // R7/R8: noise ends search early, later sync ignored
        rx_go_n = 1'b0;
        send_bit(1'b1, 1'b0);
        check("R8 no verdict before done", chan_busy | chan_clear, 1'b0);
        noise_in = 1'b1;
        @(posedge clk); #1 noise_in = 1'b0;
        check("R7 done on noise", done_flag, 1'b1);
        check("R7 irq on noise", irq_n, 1'b0);
        check("R8 clear on noise", chan_clear, 1'b1);
        send_sync(11);
        check("R7 sync ignored", sync_found, 1'b0);
        go_idle();

        // R7/R8: long-run indication
        rx_go_n = 1'b0;
        @(posedge clk); #1 long_in = 1'b1;
        @(posedge clk); #1 long_in = 1'b0;
        check("R7 done on long", done_flag, 1'b1);
        check("R8 clear on long", chan_clear, 1'b1);
        check("R8 not busy on long", chan_busy, 1'b0);
        go_idle();

        done_run = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule